// File: doc/BRIEF.md
# Calendar Clock with Alarm

This block keeps the wall-clock time and the calendar. Seconds, minutes, hours, day of week, day of month, month and year sit in a byte-wide register file. A host reaches that file through a plain bus with a 4-bit address. Three more bytes hold an alarm time for seconds, minutes and hours, and two control bytes select the data format, the hour format and the state of the timebase.

A prescaler counts `TICKS_PER_SEC` cycles of `clk_i` for each second. At the end of each count the block performs an update: it advances the time and calendar, carrying across every field, and it compares the new time with the alarm bytes. An update-in-progress flag rises `LEAD_TICKS + UPD_TICKS` cycles before the update. While that flag is high, host writes to the time and alarm bytes are dropped, which tells the host to wait.

Software sets the clock while a hold bit freezes all updates. It can also stop the timebase altogether by writing a stop code into the divider field. Fields can be stored as BCD or as binary, and hours can use 24-hour form or 12-hour form with a PM flag.

Top module: `rtc_core`

## Requirements
- R1: The register map is: 0 sec, 1 sec alarm, 2 min, 3 min alarm, 4 hour, 5 hour alarm, 6 day of week, 7 day of month, 8 month, 9 year, 10 control A, 11 control B, 12 reads 0x00, 13 reads 0x80 (time valid). After reset the time reads 00:00:00, day of week 1, date 01/01, year 00, control A 0x20, control B 0x02, and `upd_o` and `alarm_o` are low. `rdata_o` follows `addr_i` combinationally.
- R2: `uip_o`, also readable as control A bit 7, is high in the `LEAD_TICKS + UPD_TICKS` cycles before an update and low otherwise. The update happens once every `TICKS_PER_SEC` cycles. `upd_o` is a one-cycle pulse in the cycle after the update edge, and in that cycle `uip_o` is low.
- R3: An update adds one to seconds and carries 59→0 into minutes, 59→0 into hours, and the end of the day into day of week (7→1) and day of month. Day of month carries into month (12→1), and month carries into year (99→00).
- R4: April, June, September and November have 30 days. February has 29 days when the year is a multiple of 4 (including 00) and 28 days otherwise. The other months have 31 days.
- R5: Control B bit 2 = 1 stores every time, date and alarm field as binary. With the bit at 0 each field is packed BCD (tens digit in bits 7:4).
- R6: While control B bit 7 (hold) is 1, no update happens, `upd_o` stays low and `uip_o` stays low.
- R7: Control B bit 1 = 1 selects 24-hour hours (0..23). With the bit at 0 the hour byte holds 1..12 in bits 6:0 and PM in bit 7. The hour advances 12→1, and going from 11 to 12 toggles PM. The day advances only from PM 11 to AM 12.
- R8: `alarm_o` pulses together with `upd_o` when the updated seconds, minutes and hours all match their alarm bytes. It stays low when any one of them differs.
- R9: An alarm byte whose bits 7:6 are both 1 matches any value of its field.
- R10: A write to addresses 0..9 is dropped while `uip_o` is 1 and hold is 0. Otherwise it takes effect at the clock edge.
- R11: Writing 110 or 111 into control A bits 6:4 stops the prescaler: no update and `uip_o` low. Writing another code restarts it, and the first update then follows `TICKS_PER_SEC` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase and bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| uip_o | output | 1 | Update-in-progress warning |
| upd_o | output | 1 | Update-done pulse |
| alarm_o | output | 1 | Alarm-match pulse |

## Verification
The bench goes after the carry chain at its edges:
- the year-end rollover to 00, with day of week 7→1;
- the 28th of February in leap and non-leap years, including year 00;
- 30-day and 31-day month ends, in both BCD and binary.

A design that got the carries wrong would leave a field at an illegal value such as 0x60 or 32, or would skip or repeat the 29th. The 12-hour cases cover AM 11→PM 12, PM 11→AM 12 with a day step, and PM 12→PM 1. A wrong PM toggle would move the date at noon. The bench also times the warning window against the update pulse and checks that a write landing inside the window is lost. It then confirms that the hold bit and the divider stop code both freeze the seconds, and that the alarm fires on an exact match and on wildcards but not on a near miss.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 4;
  localparam int DW     = 8;
  localparam int N_TREG = 10;
  localparam int N_AL   = 3;

  localparam logic [ADDR_W-1:0] A_SEC  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'd2;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'd4;
  localparam logic [ADDR_W-1:0] A_CTLA = 4'd10;
  localparam logic [ADDR_W-1:0] A_CTLB = 4'd11;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd12;
  localparam logic [ADDR_W-1:0] A_VLD  = 4'd13;

  localparam int B_HOLD = 7;
  localparam int B_BIN  = 2;
  localparam int B_H24  = 1;

  localparam logic [6:0]    CTLA_RST = 7'h20;
  localparam logic [DW-1:0] CTLB_RST = 8'h02;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] dow;
    logic [7:0] dom;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  function automatic logic [7:0] enc(input logic [6:0] n, input logic bin);
    logic [6:0] t, u;
    t = n / 7'd10;
    u = n % 7'd10;
    return bin ? {1'b0, n} : {t[3:0], u[3:0]};
  endfunction

  function automatic logic [6:0] dec(input logic [7:0] v, input logic bin);
    logic [6:0] hi;
    hi = {3'b0, v[7:4]};
    return bin ? v[6:0] : hi * 7'd10 + {3'b0, v[3:0]};
  endfunction

  function automatic logic [6:0] days_in_month(input logic [6:0] mo, input logic [6:0] yr);
    case (mo)
      7'd2:                       return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick.sv
module rtc_tick #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int LEAD_TICKS    = 8,
  parameter int UPD_TICKS     = 65
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic hold_i,
  output logic uip_o,
  output logic step_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] WIN  = CW'(TICKS_PER_SEC - LEAD_TICKS - UPD_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (stop_i)          cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // hold suppresses both the warning and the update itself
  assign uip_o  = !stop_i && !hold_i && (cnt_q >= WIN);
  assign step_o = !stop_i && !hold_i && (cnt_q == LAST);
endmodule

// File: rtl/rtc_next.sv
module rtc_next
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  input  logic      bin_i,
  input  logic      h24_i,
  output rtc_time_t nxt_o
);
  logic [6:0] s, m, h24v, h12v, dw, dm, mo, yr, dim;
  logic       pm, sec_c, min_c, day_c, dom_c, mon_c;
  logic [7:0] h_enc;

  assign s    = dec(cur_i.sec, bin_i);
  assign m    = dec(cur_i.min, bin_i);
  assign h24v = dec(cur_i.hour, bin_i);
  assign h12v = dec({1'b0, cur_i.hour[6:0]}, bin_i);
  assign pm   = cur_i.hour[7];
  assign dw   = dec(cur_i.dow, bin_i);
  assign dm   = dec(cur_i.dom, bin_i);
  assign mo   = dec(cur_i.mon, bin_i);
  assign yr   = dec(cur_i.year, bin_i);
  assign dim  = days_in_month(mo, yr);

  assign sec_c = (s >= 7'd59);
  assign min_c = sec_c && (m >= 7'd59);
  assign day_c = min_c && (h24_i ? (h24v >= 7'd23) : (pm && h12v == 7'd11));
  assign dom_c = day_c && (dm >= dim);
  assign mon_c = dom_c && (mo >= 7'd12);

  // 12-hour: 12 -> 1, PM flips on 11 -> 12
  assign h_enc = h24_i ? enc((h24v >= 7'd23) ? 7'd0 : h24v + 7'd1, bin_i)
                       : (enc((h12v >= 7'd12) ? 7'd1 : h12v + 7'd1, bin_i)
                          | {pm ^ (h12v == 7'd11), 7'b0});

  always_comb begin
    nxt_o      = cur_i;
    nxt_o.sec  = enc(sec_c ? 7'd0 : s + 7'd1, bin_i);
    if (sec_c) nxt_o.min  = enc((m >= 7'd59) ? 7'd0 : m + 7'd1, bin_i);
    if (min_c) nxt_o.hour = h_enc;
    if (day_c) begin
      nxt_o.dow = enc((dw >= 7'd7) ? 7'd1 : dw + 7'd1, bin_i);
      nxt_o.dom = enc(dom_c ? 7'd1 : dm + 7'd1, bin_i);
    end
    if (dom_c) nxt_o.mon  = enc(mon_c ? 7'd1 : mo + 7'd1, bin_i);
    if (mon_c) nxt_o.year = enc((yr >= 7'd99) ? 7'd0 : yr + 7'd1, bin_i);
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int NF = 3
) (
  input  logic [NF-1:0][7:0] tm_i,
  input  logic [NF-1:0][7:0] al_i,
  output logic               hit_o
);
  logic [NF-1:0] m;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign m[g] = (al_i[g][7:6] == 2'b11) || (al_i[g] == tm_i[g]);
  end

  assign hit_o = &m;
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int LEAD_TICKS    = 8,
  parameter int UPD_TICKS     = 65
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              uip_o,
  output logic              upd_o,
  output logic              alarm_o
);
  logic [DW-1:0] regs_q [N_TREG];
  logic [6:0]    ctla_q;
  logic [DW-1:0] ctlb_q;
  logic          upd_q, alarm_q;
  logic          stop, step, hit, wr_ok;
  rtc_time_t     cur, nxt;

  assign stop  = (ctla_q[6:5] == 2'b11);
  assign wr_ok = we_i && (addr_i < ADDR_W'(N_TREG)) && (ctlb_q[B_HOLD] || !uip_o);
  assign cur   = '{sec: regs_q[0], min: regs_q[2], hour: regs_q[4], dow: regs_q[6],
                   dom: regs_q[7], mon: regs_q[8], year: regs_q[9]};

  rtc_tick #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .LEAD_TICKS   (LEAD_TICKS),
    .UPD_TICKS    (UPD_TICKS)
  ) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stop_i(stop),
    .hold_i(ctlb_q[B_HOLD]),
    .uip_o (uip_o),
    .step_o(step)
  );

  rtc_next u_next (
    .cur_i(cur),
    .bin_i(ctlb_q[B_BIN]),
    .h24_i(ctlb_q[B_H24]),
    .nxt_o(nxt)
  );

  rtc_alarm #(.NF(N_AL)) u_alarm (
    .tm_i ({nxt.hour, nxt.min, nxt.sec}),
    .al_i ({regs_q[5], regs_q[3], regs_q[1]}),
    .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_TREG; i++)
        regs_q[i] <= (i >= 6 && i <= 8) ? 8'h01 : 8'h00;
      ctla_q  <= CTLA_RST;
      ctlb_q  <= CTLB_RST;
      upd_q   <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      if (step) begin
        regs_q[0] <= nxt.sec;
        regs_q[2] <= nxt.min;
        regs_q[4] <= nxt.hour;
        regs_q[6] <= nxt.dow;
        regs_q[7] <= nxt.dom;
        regs_q[8] <= nxt.mon;
        regs_q[9] <= nxt.year;
      end
      // step implies uip high and hold low, so wr_ok never collides with it
      if (wr_ok) regs_q[addr_i] <= wdata_i;
      if (we_i && addr_i == A_CTLA) ctla_q <= wdata_i[6:0];
      if (we_i && addr_i == A_CTLB) ctlb_q <= wdata_i;
      upd_q   <= step;
      alarm_q <= step && hit;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < ADDR_W'(N_TREG)) rdata_o = regs_q[addr_i];
    else begin
      case (addr_i)
        A_CTLA:  rdata_o = {uip_o, ctla_q};
        A_CTLB:  rdata_o = ctlb_q;
        A_FLAG:  rdata_o = 8'h00;
        A_VLD:   rdata_o = 8'h80;
        default: rdata_o = 8'h00;
      endcase
    end
  end

  assign upd_o   = upd_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic       uip_i,
  input logic       upd_i,
  input logic       alarm_i,
  input logic       hold_i,
  input logic [7:0] sec_i
);
  a_r2_upd_follows_uip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> $past(uip_i));

  a_r2_upd_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !upd_i);

  a_r6_hold_blocks_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !upd_i);

  a_r8_alarm_with_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i |-> upd_i);

  a_r10_sec_moves_by_write_or_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sec_i) |-> ($past(we_i) || upd_i));
endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .uip_i  (uip_o),
  .upd_i  (upd_o),
  .alarm_i(alarm_o),
  .hold_i (ctlb_q[7]),
  .sec_i  (regs_q[0])
);

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
  localparam int CLK_P = 10;
  localparam int TPS   = 16;
  localparam int LEAD  = 2;
  localparam int UPD   = 2;
  localparam int NV    = 11;

  logic       clk, rst_n, we;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic       uip, upd, alarm;
  int         n_cmp = 0, n_bad = 0;

  rtc_core #(.TICKS_PER_SEC(TPS), .LEAD_TICKS(LEAD), .UPD_TICKS(UPD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .uip_o(uip), .upd_o(upd), .alarm_o(alarm)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  // ctrl, sec,min,hour,dow,dom,mon,year, then expected sec..year after one update
  localparam logic [7:0] VEC [NV][15] = '{
    '{8'h02, 8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00}, // R3
    '{8'h02, 8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h04,8'h29,8'h02,8'h24}, // R4
    '{8'h02, 8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h23}, // R4
    '{8'h06, 8'h3B,8'h3B,8'h17,8'h02,8'h1E,8'h04,8'h05, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h05,8'h05}, // R5
    '{8'h00, 8'h59,8'h59,8'h11,8'h05,8'h15,8'h06,8'h10, 8'h00,8'h00,8'h92,8'h05,8'h15,8'h06,8'h10}, // R7
    '{8'h00, 8'h59,8'h59,8'h91,8'h05,8'h15,8'h06,8'h10, 8'h00,8'h00,8'h12,8'h06,8'h16,8'h06,8'h10}, // R7
    '{8'h00, 8'h59,8'h59,8'h92,8'h05,8'h15,8'h06,8'h10, 8'h00,8'h00,8'h81,8'h05,8'h15,8'h06,8'h10}, // R7
    '{8'h04, 8'h3B,8'h3B,8'h8B,8'h06,8'h1F,8'h01,8'h00, 8'h00,8'h00,8'h0C,8'h07,8'h01,8'h02,8'h00}, // R5 R7
    '{8'h02, 8'h09,8'h30,8'h14,8'h01,8'h10,8'h07,8'h50, 8'h10,8'h30,8'h14,8'h01,8'h10,8'h07,8'h50}, // R3
    '{8'h02, 8'h59,8'h59,8'h23,8'h02,8'h30,8'h09,8'h01, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h10,8'h01}, // R4
    '{8'h02, 8'h59,8'h59,8'h23,8'h01,8'h29,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,8'h00}  // R4
  };
  localparam logic [3:0] FADDR [7] = '{4'd0, 4'd2, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9};

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wait_upd(input string tag);
    for (int i = 0; i < 4*TPS; i++) begin
      @(negedge clk);
      if (upd) return;
    end
    chk(tag, 8'h00, 8'h01);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v, sv;
    int         cnt;
    bit         seen;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and fixed registers
    chk("R1 upd_o reset", {7'b0, upd}, 8'h00);
    chk("R1 alarm_o reset", {7'b0, alarm}, 8'h00);
    rd(4'd0, v);  chk("R1 sec reset", v, 8'h00);
    rd(4'd6, v);  chk("R1 dow reset", v, 8'h01);
    rd(4'd8, v);  chk("R1 month reset", v, 8'h01);
    rd(4'd11, v); chk("R1 ctlB reset", v, 8'h02);
    rd(4'd12, v); chk("R1 flag reads 0", v, 8'h00);
    rd(4'd13, v); chk("R1 valid reads 80", v, 8'h80);

    // table of rollover vectors: R3 R4 R5 R7
    for (int k = 0; k < NV; k++) begin
      wr(4'd11, VEC[k][0] | 8'h80);
      for (int f = 0; f < 7; f++) wr(FADDR[f], VEC[k][1+f]);
      wr(4'd11, VEC[k][0]);
      wait_upd("R3 update pulse");
      for (int f = 0; f < 7; f++) begin
        rd(FADDR[f], v);
        chk($sformatf("R3/R4/R5/R7 vec %0d field %0d", k, f), v, VEC[k][8+f]);
      end
    end

    // R8 exact alarm match
    wr(4'd11, 8'h82);
    wr(4'd0, 8'h30); wr(4'd2, 8'h20); wr(4'd4, 8'h10);
    wr(4'd1, 8'h31); wr(4'd3, 8'h20); wr(4'd5, 8'h10);
    wr(4'd11, 8'h02);
    wait_upd("R8 update pulse");
    chk("R8 alarm on match", {7'b0, alarm}, 8'h01);
    // R9 wildcards on minutes and hours
    wr(4'd1, 8'h32); wr(4'd3, 8'hC0); wr(4'd5, 8'hFF);
    wait_upd("R9 update pulse");
    chk("R9 alarm with wildcards", {7'b0, alarm}, 8'h01);
    // R8 near miss
    wr(4'd1, 8'h40);
    wait_upd("R8 update pulse");
    chk("R8 no alarm on mismatch", {7'b0, alarm}, 8'h00);

    // R2 warning window timing
    wait_upd("R2 update pulse");
    cnt = 0;
    while (!uip && cnt < 4*TPS) begin @(negedge clk); cnt++; end
    chk("R2 cycles to uip rise", 8'(cnt), 8'(TPS - LEAD - UPD));
    addr = 4'd10; #1;
    chk("R2 ctlA bit7 reads uip", rdata, 8'hA0);
    cnt = 0;
    while (uip && cnt < 4*TPS) begin @(negedge clk); cnt++; end
    chk("R2 uip high cycles", 8'(cnt), 8'(LEAD + UPD));
    chk("R2 upd as uip falls", {7'b0, upd}, 8'h01);

    // R10 write inside the window is dropped
    wait_upd("R10 update pulse");
    rd(4'd0, sv);
    while (!uip) @(negedge clk);
    wr(4'd0, 8'h45);
    rd(4'd0, v);
    chk("R10 write dropped in window", v, sv);
    wait_upd("R10 update pulse");
    rd(4'd0, v);
    chk("R10 sec advanced after drop", v, (sv[3:0] == 4'h9) ? {sv[7:4] + 4'h1, 4'h0} : sv + 8'h01);
    wr(4'd0, 8'h45);
    rd(4'd0, v);
    chk("R10 write accepted outside window", v, 8'h45);

    // R6 hold freezes updates
    wr(4'd11, 8'h82);
    seen = 1'b0;
    for (int i = 0; i < 3*TPS; i++) begin
      @(negedge clk);
      if (upd || uip) seen = 1'b1;
    end
    chk("R6 no uip/upd under hold", {7'b0, seen}, 8'h00);
    rd(4'd0, v); chk("R6 sec frozen", v, 8'h45);

    // R11 divider stop code
    wr(4'd11, 8'h02);
    wr(4'd10, 8'h60);
    seen = 1'b0;
    for (int i = 0; i < 3*TPS; i++) begin
      @(negedge clk);
      if (upd || uip) seen = 1'b1;
    end
    chk("R11 no uip/upd when stopped", {7'b0, seen}, 8'h00);
    rd(4'd10, v); chk("R11 ctlA readback", v, 8'h60);
    rd(4'd0, v);  chk("R11 sec frozen", v, 8'h45);
    wr(4'd10, 8'h20);
    cnt = 0;
    while (!upd && cnt < 4*TPS) begin @(negedge clk); cnt++; end
    chk("R11 first update after restart", 8'(cnt), 8'(TPS));
    rd(4'd0, v);  chk("R11 sec resumes", v, 8'h46);

    summary();
  end
endmodule